// File: doc/BRIEF.md
# EDO DRAM Page-Mode Controller

This block sits between a simple synchronous request port and an asynchronous 1M x 16 extended-data-out DRAM with a shared 10-bit address bus. A host presents a 20-bit word address, a write flag, two byte enables, a beat count and write data. The controller opens the row, strobes one or more columns of that row in page mode, and closes the row again. Write beats are early writes. Read beats are captured at the end of each low CAS phase, which relies on the extended output hold of the part.

Each byte enable selects one of two CAS strobes, so a request can move the lower byte, the upper byte or the whole word. A free-running interval counter raises a refresh request. The sequencer serves that request at its next idle point, ahead of any waiting host request, with a CAS-before-RAS cycle. Every analog timing figure is a nanosecond parameter that is rounded up to whole clock cycles.

Top module: `edo_dram_ctrl`

## Requirements
- R1: When RAS falls for an access, `dram_addr` carries `addr[19:10]`. At each CAS fall it carries the column of that beat, which is `addr[9:0]` plus the beat index, modulo 1024. The row never changes within a request.
- R2: Byte enable bit 0 selects `casl_n`, which strobes data bits 7:0. Bit 1 selects `cash_n`, which strobes bits 15:8. A strobe whose enable is clear stays high for the whole request, and the byte behind it is left unchanged in the memory.
- R3: A read returns, for every beat and in column order, the word last written on each enabled lane.
- R4: In a write, `we_n` is low from the RAS fall onwards, and `dq_oe` is high with the beat's data at every CAS fall. `dq_oe` is high only during a write beat and the cycle after it. `oe_n` is low only while a CAS strobe is low, and never at the same time as `dq_oe`.
- R5: RAS stays high for at least the precharge count before every fall. The first CAS fall comes at least the RAS-to-CAS count after RAS falls. Every CAS low phase lasts at least the CAS access count.
- R6: A refresh lowers both CAS strobes at least one cycle before RAS falls and keeps them low during that fall, with `we_n` high.
- R7: Refreshes arrive at an average rate of at least one per refresh interval.
- R8: A refresh that falls due is started at the next idle point, before any host request. `ready` is low while RAS is low, so two refreshes are never further apart than one interval plus one request length.
- R9: A request is taken when `req` and `ready` are both high. `rdata_valid` pulses once per read beat and `wbeat_taken` pulses once per write beat. `done` pulses for one cycle with the last beat.
- R10: During reset RAS, both CAS strobes, `we_n` and `oe_n` are high, `dq_oe` is low and `ready` is low. `ready` rises within a few cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request |
| ready | output | 1 | Controller can take a request |
| addr | input | 20 | Word address, row in the upper half |
| we | input | 1 | 1 = write request |
| be | input | 2 | Byte enables (bit 0 lower byte) |
| blen | input | 3 | Number of beats minus one |
| wdata | input | 16 | Write data of the current beat |
| wbeat_taken | output | 1 | The current write word was consumed |
| rdata | output | 16 | Read data |
| rdata_valid | output | 1 | One pulse per read beat |
| done | output | 1 | Last beat of a request completed |
| ras_n | output | 1 | Row strobe |
| casl_n | output | 1 | Lower byte column strobe |
| cash_n | output | 1 | Upper byte column strobe |
| we_n | output | 1 | Write enable |
| oe_n | output | 1 | Output enable |
| dram_addr | output | 10 | Multiplexed address |
| dq_out | output | 16 | Data driven to the memory |
| dq_oe | output | 1 | Data bus drive enable |
| dq_in | input | 16 | Data from the memory |

## Verification
The bench keeps the 100 MHz timing defaults, which give four cycles from RAS to CAS, two cycles of CAS low, one cycle of CAS precharge, three cycles of RAS precharge and five cycles of minimum RAS low. It lowers the refresh interval to 2000 ns, which is 200 cycles. At that rate dozens of refreshes collide with back-to-back bursts within a short run, so refresh priority and refresh spacing are exercised many times. A column wrap at the end of a row, overlapping byte-lane writes and eight-beat bursts are driven as directed cases.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [2:0] {
    ST_PRECH,
    ST_IDLE,
    ST_ROW,
    ST_CASLO,
    ST_CASHI,
    ST_RFCAS,
    ST_RFRAS,
    ST_RFHOLD
  } seq_st_t;

  // nanoseconds to whole clock cycles, rounded up, at least one
  function automatic int ns_to_cyc(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_wait_counter.sv
module edo_wait_counter #(
  parameter int CW      = 4,
  parameter int RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CW'(RST_VAL);
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
  parameter int INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pend
);

  localparam int TW = $clog2(INTERVAL + 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          tick;

  assign tick = (cnt_q == TW'(INTERVAL - 1));

  always_comb begin
    cnt_d  = tick ? '0 : cnt_q + 1'b1;
    pend_d = pend_q;
    if (ack)  pend_d = 1'b0;
    if (tick) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/edo_col_tracker.sv
module edo_col_tracker #(
  parameter int CW = 10,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] start_col,
  input  logic [LW-1:0] start_len,
  input  logic          step,
  output logic [CW-1:0] col,
  output logic          last,
  output logic          empty
);

  logic [CW-1:0] col_q, col_d;
  logic [LW:0]   left_q, left_d;

  always_comb begin
    col_d  = col_q;
    left_d = left_q;
    if (start) begin
      col_d  = start_col;
      left_d = {1'b0, start_len} + 1'b1;
    end else if (step) begin
      col_d  = col_q + 1'b1;           // wraps inside the row
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      left_q <= '0;
    end else begin
      col_q  <= col_d;
      left_q <= left_d;
    end
  end

  assign col   = col_q;
  assign last  = (left_q == (LW+1)'(1));
  assign empty = (left_q == '0);

endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl #(
  parameter int CLK_MHZ  = 100,
  parameter int MA_W     = 10,
  parameter int LANE_W   = 8,
  parameter int BL_W     = 3,
  parameter int T_RAC_NS = 50,
  parameter int T_CAC_NS = 13,
  parameter int T_PC_NS  = 20,
  parameter int T_RP_NS  = 30,
  parameter int T_RAS_NS = 50,
  parameter int T_CSR_NS = 5,
  parameter int T_CHR_NS = 10,
  parameter int REF_NS   = 15600
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  output logic                ready,
  input  logic [2*MA_W-1:0]   addr,
  input  logic                we,
  input  logic [1:0]          be,
  input  logic [BL_W-1:0]     blen,
  input  logic [2*LANE_W-1:0] wdata,
  output logic                wbeat_taken,
  output logic [2*LANE_W-1:0] rdata,
  output logic                rdata_valid,
  output logic                done,
  output logic                ras_n,
  output logic                casl_n,
  output logic                cash_n,
  output logic                we_n,
  output logic                oe_n,
  output logic [MA_W-1:0]     dram_addr,
  output logic [2*LANE_W-1:0] dq_out,
  output logic                dq_oe,
  input  logic [2*LANE_W-1:0] dq_in
);
  import edo_pkg::*;

  localparam int DQ_W   = 2 * LANE_W;
  localparam int RCD_C  = ns_to_cyc(T_RAC_NS - T_CAC_NS, CLK_MHZ);
  localparam int CAS_C  = ns_to_cyc(T_CAC_NS, CLK_MHZ);
  localparam int CP_C   = ns_to_cyc(T_PC_NS - T_CAC_NS, CLK_MHZ);
  localparam int RP_C   = ns_to_cyc(T_RP_NS, CLK_MHZ);
  localparam int RAS_C  = ns_to_cyc(T_RAS_NS, CLK_MHZ);
  localparam int CSR_C  = ns_to_cyc(T_CSR_NS, CLK_MHZ);
  localparam int CHR_C  = ns_to_cyc(T_CHR_NS, CLK_MHZ);
  localparam int REF_C  = ns_to_cyc(REF_NS, CLK_MHZ);
  localparam int MAXC   = max_of(max_of(max_of(RP_C, RCD_C), max_of(CAS_C, CP_C)),
                                 max_of(RAS_C, max_of(CSR_C, CHR_C)));
  localparam int CNT_W  = $clog2(MAXC + 1);

  // reset: asynchronous assertion, synchronous release
  logic rs1_q, rs2_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_sync_n = rs2_q;

  seq_st_t st_q, st_d;
  logic    wait_zero, wait_load;
  logic [CNT_W-1:0] wait_val;
  logic    ref_pend, ref_ack;
  logic    accept;
  logic    trk_step, trk_last, trk_empty;
  logic [MA_W-1:0] trk_col;
  logic    wr_q, wr_sel;
  logic [1:0] be_q;
  logic [MA_W-1:0] row_q;
  logic [CNT_W-1:0] age_q, age_d;
  logic    ras_ok;

  // output registers
  logic    ras_q, ras_d;
  logic [1:0] cas_q, cas_d;
  logic    we_q, we_d, oe_q, oe_d, dqoe_q, dqoe_d;
  logic [MA_W-1:0] ma_q, ma_d;
  logic [DQ_W-1:0] dqo_q, rd_q;
  logic    rv_q, rv_d, dn_q, dn_d, wbt_q, wbt_d;
  logic    beat_end;

  assign ready  = (st_q == ST_IDLE) && !ref_pend;       // R8
  assign accept = req && ready;                          // R9
  assign ras_ok = (age_q >= CNT_W'(RAS_C));
  assign beat_end = (st_q == ST_CASLO) && wait_zero;

  edo_refresh_timer #(.INTERVAL(REF_C)) u_ref (
    .clk(clk), .rst_n(rst_sync_n), .ack(ref_ack), .pend(ref_pend)
  );

  edo_wait_counter #(.CW(CNT_W), .RST_VAL(RP_C - 1)) u_wait (
    .clk(clk), .rst_n(rst_sync_n), .load(wait_load), .load_val(wait_val),
    .zero(wait_zero)
  );

  edo_col_tracker #(.CW(MA_W), .LW(BL_W)) u_col (
    .clk(clk), .rst_n(rst_sync_n), .start(accept), .start_col(addr[MA_W-1:0]),
    .start_len(blen), .step(trk_step), .col(trk_col), .last(trk_last),
    .empty(trk_empty)
  );

  // sequencer next state
  always_comb begin
    st_d     = st_q;
    ref_ack  = 1'b0;
    trk_step = 1'b0;
    case (st_q)
      ST_PRECH:  if (wait_zero) st_d = ST_IDLE;
      ST_IDLE: begin
        if (ref_pend) begin                              // R8 refresh first
          st_d    = ST_RFCAS;
          ref_ack = 1'b1;
        end else if (accept) begin
          st_d = ST_ROW;
        end
      end
      ST_ROW:    if (wait_zero) st_d = ST_CASLO;
      ST_CASLO: begin
        if (wait_zero) begin
          st_d     = ST_CASHI;
          trk_step = 1'b1;
        end
      end
      ST_CASHI: begin
        if (wait_zero) begin
          if (!trk_empty)  st_d = ST_CASLO;              // next page beat
          else if (ras_ok) st_d = ST_PRECH;
        end
      end
      ST_RFCAS:  if (wait_zero) st_d = ST_RFRAS;         // R6 CAS leads RAS
      ST_RFRAS:  if (wait_zero) st_d = ST_RFHOLD;
      ST_RFHOLD: if (ras_ok)    st_d = ST_PRECH;
      default:   st_d = ST_PRECH;
    endcase
  end

  // per-state wait length
  always_comb begin
    wait_load = (st_d != st_q);
    case (st_d)
      ST_PRECH: wait_val = CNT_W'(RP_C - 1);
      ST_ROW:   wait_val = CNT_W'(RCD_C - 1);
      ST_CASLO: wait_val = CNT_W'(CAS_C - 1);
      ST_CASHI: wait_val = CNT_W'(CP_C - 1);
      ST_RFCAS: wait_val = CNT_W'(CSR_C - 1);
      ST_RFRAS: wait_val = CNT_W'(CHR_C - 1);
      default:  wait_val = '0;
    endcase
  end

  // pin decode from the next state
  always_comb begin
    wr_sel = accept ? we : wr_q;
    ras_d  = !(st_d inside {ST_ROW, ST_CASLO, ST_CASHI, ST_RFRAS, ST_RFHOLD});
    for (int i = 0; i < 2; i++) begin
      cas_d[i] = !(((st_d == ST_CASLO) && be_q[i]) ||
                   (st_d inside {ST_RFCAS, ST_RFRAS}));          // R2, R6
    end
    we_d   = !(wr_sel && (st_d inside {ST_ROW, ST_CASLO, ST_CASHI}));  // R4
    oe_d   = !(!wr_q && (st_d == ST_CASLO));
    dqoe_d = wr_q && ((st_d == ST_CASLO) ||
                      ((st_q == ST_CASLO) && (st_d == ST_CASHI)));
    ma_d   = ((st_d == ST_ROW) && (st_q != ST_ROW)) ? addr[2*MA_W-1:MA_W] : trk_col; // R1
    wbt_d  = wr_q && (st_d == ST_CASLO) && (st_q != ST_CASLO);
    rv_d   = beat_end && !wr_q;
    dn_d   = beat_end && trk_last;
    age_d  = '0;
    if (!ras_d) begin
      if (ras_q)       age_d = CNT_W'(1);
      else if (ras_ok) age_d = age_q;
      else             age_d = age_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= ST_PRECH;
      wr_q   <= 1'b0;
      be_q   <= 2'b00;
      row_q  <= '0;
      age_q  <= '0;
      ras_q  <= 1'b1;
      cas_q  <= 2'b11;
      we_q   <= 1'b1;
      oe_q   <= 1'b1;
      dqoe_q <= 1'b0;
      ma_q   <= '0;
      dqo_q  <= '0;
      rd_q   <= '0;
      rv_q   <= 1'b0;
      dn_q   <= 1'b0;
      wbt_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      age_q  <= age_d;
      ras_q  <= ras_d;
      cas_q  <= cas_d;
      we_q   <= we_d;
      oe_q   <= oe_d;
      dqoe_q <= dqoe_d;
      ma_q   <= ma_d;
      rv_q   <= rv_d;
      dn_q   <= dn_d;
      wbt_q  <= wbt_d;
      if (accept) begin
        wr_q  <= we;
        be_q  <= be;
        row_q <= addr[2*MA_W-1:MA_W];
      end
      if (wbt_d) dqo_q <= wdata;                         // R4
      if (rv_d)  rd_q  <= dq_in;                         // R3 late capture
    end
  end

  assign ras_n       = ras_q;
  assign casl_n      = cas_q[0];
  assign cash_n      = cas_q[1];
  assign we_n        = we_q;
  assign oe_n        = oe_q;
  assign dram_addr   = ma_q;
  assign dq_out      = dqo_q;
  assign dq_oe       = dqoe_q;
  assign rdata       = rd_q;
  assign rdata_valid = rv_q;
  assign done        = dn_q;
  assign wbeat_taken = wbt_q;

endmodule

// File: rtl/edo_dram_ctrl_chk.sv
module edo_dram_ctrl_chk #(
  parameter int CLK_MHZ  = 100,
  parameter int T_RP_NS  = 30,
  parameter int T_RAC_NS = 50,
  parameter int T_CAC_NS = 13
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic casl_n,
  input logic cash_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe,
  input logic ready,
  input logic done
);
  localparam int RP_C  = edo_pkg::ns_to_cyc(T_RP_NS, CLK_MHZ);
  localparam int RCD_C = edo_pkg::ns_to_cyc(T_RAC_NS - T_CAC_NS, CLK_MHZ);

  logic [7:0] hi_cnt, lo_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= ras_n  ? ((hi_cnt == 8'hff) ? hi_cnt : hi_cnt + 1'b1) : '0;
      lo_cnt <= !ras_n ? ((lo_cnt == 8'hff) ? lo_cnt : lo_cnt + 1'b1) : '0;
    end
  end

  a_r5_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> hi_cnt >= 8'(RP_C));
  a_r5_ras_to_cas: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(casl_n) || $fell(cash_n)) && !ras_n |-> lo_cnt >= 8'(RCD_C));
  a_r6_cbr_order: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) && !casl_n |-> $past(!casl_n) && !cash_n && $past(!cash_n) && we_n);
  a_r6_cas_pair: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(casl_n) || $fell(cash_n)) && ras_n |-> !casl_n && !cash_n);
  a_r4_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && !oe_n));
  a_r4_oe_with_cas: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!casl_n || !cash_n));
  a_r4_we_in_row: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ras_n);
  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !ready);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk #(
  .CLK_MHZ(CLK_MHZ), .T_RP_NS(T_RP_NS), .T_RAC_NS(T_RAC_NS), .T_CAC_NS(T_CAC_NS)
) i_chk (
  .clk(clk), .rst_n(rst_sync_n), .ras_n(ras_n), .casl_n(casl_n), .cash_n(cash_n),
  .we_n(we_n), .oe_n(oe_n), .dq_oe(dq_oe), .ready(ready), .done(done)
);

// File: tb/test_edo_dram_ctrl.sv
module test_edo_dram_ctrl;

  localparam int RCD_C = 4;
  localparam int CAS_C = 2;
  localparam int RP_C  = 3;
  localparam int REF_C = 200;
  localparam int SLACK = 80;

  logic        clk, rst_n, req, ready, we, wbeat_taken, rdata_valid, done;
  logic [19:0] addr;
  logic [1:0]  be;
  logic [2:0]  blen;
  logic [15:0] wdata, rdata, dq_out, dq_in;
  logic        ras_n, casl_n, cash_n, we_n, oe_n, dq_oe;
  logic [9:0]  dram_addr;

  edo_dram_ctrl #(.REF_NS(2000)) i_edo_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .addr(addr), .we(we),
    .be(be), .blen(blen), .wdata(wdata), .wbeat_taken(wbeat_taken),
    .rdata(rdata), .rdata_valid(rdata_valid), .done(done), .ras_n(ras_n),
    .casl_n(casl_n), .cash_n(cash_n), .we_n(we_n), .oe_n(oe_n),
    .dram_addr(dram_addr), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      chk(1'b0, "watchdog", cyc, 100000);
      finish_run();
    end
  end

  // memory contents before any write, and the two memories
  function automatic logic [15:0] init_word(input int idx);
    return 16'(idx) ^ 16'(idx >> 5) ^ 16'h5A3C;
  endfunction
  logic [15:0] dmem [int];
  logic [15:0] rmem [int];
  function automatic logic [15:0] dm_get(input int idx);
    return dmem.exists(idx) ? dmem[idx] : init_word(idx);
  endfunction
  function automatic logic [15:0] rm_get(input int idx);
    return rmem.exists(idx) ? rmem[idx] : init_word(idx);
  endfunction
  function automatic logic [15:0] lane_mask(input logic [1:0] b);
    return {{8{b[1]}}, {8{b[0]}}};
  endfunction

  // expectation of the request in flight
  logic [9:0] exp_row, exp_col0;
  logic [1:0] exp_be;
  int  mbeat = 0;
  logic [9:0] cur_row;

  // DRAM pin model, sampled on the falling clock edge
  logic prev_ras = 1, prev_cl = 1, prev_ch = 1;
  int hi_cnt = 0, lo_cnt = 0, cl_cnt = 0, ch_cnt = 0;
  int ref_count = 0, last_ref = 0, run_start = 0;
  bit model_on = 0;

  always @(negedge clk) begin
    if (model_on) begin
      if (prev_ras && !ras_n) begin
        chk(hi_cnt >= RP_C, "R5 precharge", hi_cnt, RP_C);
        if (!casl_n && !cash_n) begin
          chk(!prev_cl && !prev_ch && we_n, "R6 cbr order", {prev_ch, prev_cl, we_n}, 3'b001);
          chk(cyc - last_ref <= REF_C + SLACK, "R8 refresh spacing", cyc - last_ref, REF_C + SLACK);
          ref_count++;
          last_ref = cyc;
        end else begin
          chk(dram_addr == exp_row, "R1 row address", dram_addr, exp_row);
          cur_row = dram_addr;
          mbeat = 0;
        end
      end
      if (!ras_n && ((prev_cl && !casl_n) || (prev_ch && !cash_n))) begin
        int idx;
        logic [15:0] m;
        chk({!cash_n, !casl_n} == exp_be, "R2 lane strobes", {!cash_n, !casl_n}, exp_be);
        chk(dram_addr == 10'(exp_col0 + 10'(mbeat)), "R1 column", dram_addr, exp_col0 + 10'(mbeat));
        if (mbeat == 0) chk(lo_cnt >= RCD_C, "R5 ras to cas", lo_cnt, RCD_C);
        idx = {12'd0, cur_row, dram_addr};
        m = {{8{!cash_n}}, {8{!casl_n}}};
        if (!we_n) begin
          chk(dq_oe && oe_n, "R4 write drive", {dq_oe, oe_n}, 2'b11);
          dmem[idx] = (dm_get(idx) & ~m) | (dq_out & m);
        end else begin
          chk(!dq_oe && !oe_n, "R4 read enables", {dq_oe, oe_n}, 2'b00);
          dq_in = dm_get(idx);
        end
        mbeat++;
      end
      if (!prev_cl && casl_n && !ras_n) chk(cl_cnt >= CAS_C, "R5 cas low", cl_cnt, CAS_C);
      if (!prev_ch && cash_n && !ras_n) chk(ch_cnt >= CAS_C, "R5 cas low", ch_cnt, CAS_C);
      if (dq_oe && !oe_n) chk(1'b0, "R4 contention", 1, 0);
      hi_cnt = ras_n ? hi_cnt + 1 : 0;
      lo_cnt = !ras_n ? lo_cnt + 1 : 0;
      cl_cnt = !casl_n ? cl_cnt + 1 : 0;
      ch_cnt = !cash_n ? ch_cnt + 1 : 0;
      prev_ras = ras_n; prev_cl = casl_n; prev_ch = cash_n;
    end
  end

  task automatic do_req(input logic [19:0] a, input bit w, input logic [1:0] b,
                        input logic [2:0] n);
    logic [15:0] wbuf [8];
    int beats = 0, guard = 0;
    bit fin = 0;
    for (int i = 0; i < 8; i++) wbuf[i] = 16'($urandom);
    exp_row = a[19:10]; exp_col0 = a[9:0]; exp_be = b;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1; addr = a; we = w; be = b; blen = n; wdata = wbuf[0];
    @(negedge clk);
    req = 0;
    while (!fin && guard < 300) begin
      if (rdata_valid) begin
        int idx = {12'd0, a[19:10], 10'(a[9:0] + 10'(beats))};
        logic [15:0] e = rm_get(idx);
        chk(((rdata ^ e) & lane_mask(b)) == 0, "R3 read data", rdata & lane_mask(b), e & lane_mask(b));
        beats++;
      end
      if (wbeat_taken) begin
        int idx = {12'd0, a[19:10], 10'(a[9:0] + 10'(beats))};
        rmem[idx] = (rm_get(idx) & ~lane_mask(b)) | (wbuf[beats] & lane_mask(b));
        beats++;
        if (beats < 8) wdata = wbuf[beats];
      end
      if (done) fin = 1;
      else begin @(negedge clk); guard++; end
    end
    chk(fin && beats == int'(n) + 1, "R9 beat count", beats, int'(n) + 1);
    @(negedge clk);
    chk(!done && !rdata_valid, "R9 single done", {done, rdata_valid}, 0);
  endtask

  initial begin
    bit seen;
    void'($urandom(32'h1234_5678));
    rst_n = 0; req = 0; addr = '0; we = 0; be = 2'b11; blen = '0; wdata = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    chk({ras_n, casl_n, cash_n, we_n, oe_n} == 5'b11111, "R10 reset pins",
        {ras_n, casl_n, cash_n, we_n, oe_n}, 5'b11111);
    chk(!dq_oe && !ready && !done, "R10 reset outputs", {dq_oe, ready, done}, 0);
    rst_n = 1;
    run_start = cyc; last_ref = cyc; model_on = 1;
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (ready) seen = 1;
    end
    chk(seen, "R10 ready after reset", seen, 1);

    // column wrap inside a row, full words
    do_req({10'd5, 10'd1020}, 1, 2'b11, 3'd7);
    do_req({10'd5, 10'd1020}, 0, 2'b11, 3'd7);
    // byte lanes on overlapping words
    do_req({10'd9, 10'd40}, 1, 2'b11, 3'd3);
    do_req({10'd9, 10'd40}, 1, 2'b01, 3'd3);
    do_req({10'd9, 10'd41}, 1, 2'b10, 3'd1);
    do_req({10'd9, 10'd40}, 0, 2'b11, 3'd3);
    do_req({10'd9, 10'd40}, 0, 2'b10, 3'd0);
    // single beats at the address extremes
    do_req(20'hFFFFF, 1, 2'b11, 3'd0);
    do_req(20'hFFFFF, 0, 2'b01, 3'd0);
    do_req(20'h00000, 0, 2'b11, 3'd0);

    // back-to-back random traffic over a few rows
    for (int k = 0; k < 160; k++) begin
      logic [19:0] a;
      logic [1:0]  b;
      a = {10'($urandom_range(0, 3)), 10'($urandom)};
      b = 2'($urandom_range(1, 3));
      do_req(a, 1'($urandom), b, 3'($urandom));
    end
    // idle stretch: refreshes keep coming
    repeat (700) @(negedge clk);
    chk(ref_count >= (cyc - run_start) / REF_C - 1, "R7 refresh rate",
        ref_count, (cyc - run_start) / REF_C - 1);
    chk(cyc - last_ref <= REF_C + SLACK, "R8 refresh spacing idle", cyc - last_ref, REF_C + SLACK);
    finish_run();
  end

endmodule